// File: doc/BRIEF.md
# Clock-to-Reference Alignment Calibrator

This block runs a calibration search on the delay setting of an internal device clock. The goal is for the clock's falling edge to line up with the rising edge of a periodic reference pulse. At that point the reference is captured with the widest setup and hold margin, and the sampling instant is fixed relative to the reference edge. The delay element and the phase detector are outside the block. It drives a delay code to the delay element and reads one bit back from the phase detector. That bit says whether the reference edge leads or lags the clock edge.

Configure the sweep bounds, the step and the settle time first, then raise the enable. The reference must already be running and must stay periodic for the whole search. The block starts at the lowest code and moves upward one step at a time. After each step it waits a programmed number of reference periods and then samples the phase detector once. It stops at the first code where the detector result turns from lead to lag. If no such code appears before the upper bound, it stops there and raises an error. Software polls the done flag. Lowering the enable returns the block to idle and keeps the delay code that was reached.

Top module: `clk_ref_align_cal`

## Requirements
- R1: While reset is asserted, `dly_code` is 0 and `busy`, `done` and `err` are all low.
- R2: When idle (`busy` and `done` both low) and `cal_en` is high at a clock edge, `busy` is high after that edge and `dly_code` equals `cfg_code_min`.
- R3: While busy, a reference rising edge is a low-to-high change of `ref_in` between two clock edges. `pd_lag` is sampled only on the N-th such edge after the start or after the last step, where N is `cfg_settle` and a value of 0 counts as 1. `dly_code` does not change between samples.
- R4: A sample that neither locks (R5) nor fails (R6) advances `dly_code` by `cfg_step`, with a step of 0 counting as 1. The result is clipped to `cfg_code_max`.
- R5: `pd_lag` = 1 means lag and 0 means lead. A sample with lag that follows a lead sample at the previous code locks: `done` rises, `busy` falls, `err` stays low and `dly_code` is held. A lag on the first sample of a run does not lock.
- R6: A non-locking sample taken with `dly_code` at or above `cfg_code_max` ends the run with `done` and `err` high and `dly_code` held.
- R7: While `done` is high and `cal_en` stays high, `dly_code`, `done` and `err` do not change, whatever `pd_lag` and `ref_in` do.
- R8: `cal_en` low at a clock edge leaves `busy`, `done` and `err` low after that edge and leaves `dly_code` unchanged. This aborts a run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_en | input | 1 | Starts calibration when raised; clearing it returns the block to idle |
| cfg_code_min | input | CODE_W | First delay code of the sweep |
| cfg_code_max | input | CODE_W | Last delay code of the sweep |
| cfg_step | input | CODE_W | Code increment per step (0 counts as 1) |
| cfg_settle | input | SETTLE_W | Reference periods to wait before each sample (0 counts as 1) |
| ref_in | input | 1 | Periodic reference pulse, synchronous to clk |
| pd_lag | input | 1 | Phase detector: 1 = reference lags clock falling edge, 0 = leads |
| dly_code | output | CODE_W | Delay code driven to the clock delay element |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| err | output | 1 | Search reached the upper bound without a lead-to-lag change |

## Verification
Every result is registered, so it shows one clock edge after the inputs that cause it. A start, an abort or a lock or failure decision each appear after exactly one edge. A sample fires on the same edge where the qualifying reference rising edge is seen, and the new code is visible after that edge. The bench's behavioural model takes the same input values at each rising edge and updates its own integer state. The design outputs are compared with that state at the following falling edge, so no check depends on process order. Directed checks compute the expected final code and error flag from the sweep parameters and the detector threshold alone.

// File: rtl/cal_align_pkg.sv
package cal_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWEEP  = 2'd1,
    ST_FINISH = 2'd2
  } cal_state_e;

  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_STEP = 2'd1,
    DEC_LOCK = 2'd2,
    DEC_FAIL = 2'd3
  } cal_dec_e;

endpackage

// File: rtl/cal_ref_period_counter.sv
module cal_ref_period_counter #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                ref_in,
  input  logic [SETTLE_W-1:0] settle_cfg,
  output logic                ref_rise,
  output logic                sample_evt
);

  logic                ref_q;
  logic [SETTLE_W-1:0] edge_cnt;
  logic [SETTLE_W-1:0] last_idx;

  // index of the qualifying edge, counting from 0
  function automatic logic [SETTLE_W-1:0] settle_last(input logic [SETTLE_W-1:0] n);
    if (n == '0) return '0;
    return n - 1'b1;
  endfunction

  assign last_idx   = settle_last(settle_cfg);
  assign ref_rise   = ref_in & ~ref_q;
  assign sample_evt = run & ref_rise & (edge_cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
    end else if (!run) begin
      edge_cnt <= '0;
    end else if (ref_rise) begin
      if (sample_evt) edge_cnt <= '0;
      else            edge_cnt <= edge_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cal_phase_decider.sv
module cal_phase_decider
  import cal_align_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              sample_evt,
  input  logic              pd_lag,
  input  logic              prev_lag,
  input  logic              have_prev,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] code_max,
  output cal_dec_e          dec
);

  function automatic logic is_edge_found(input logic have, input logic prev,
                                         input logic now_lag);
    return have & ~prev & now_lag;
  endfunction

  always_comb begin
    if (!sample_evt) begin
      dec = DEC_NONE;
    end else if (is_edge_found(have_prev, prev_lag, pd_lag)) begin
      dec = DEC_LOCK;
    end else if (code >= code_max) begin
      dec = DEC_FAIL;
    end else begin
      dec = DEC_STEP;
    end
  end

endmodule

// File: rtl/cal_search_fsm.sv
module cal_search_fsm
  import cal_align_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_en,
  input  logic [CODE_W-1:0] code_min,
  input  logic [CODE_W-1:0] code_max,
  input  logic [CODE_W-1:0] code_step,
  input  logic              pd_lag,
  input  cal_dec_e          dec,
  output logic [CODE_W-1:0] code,
  output logic              prev_lag,
  output logic              have_prev,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              lock_evt,
  output logic              fail_evt
);

  localparam int SUM_W = CODE_W + 1;

  cal_state_e state;

  function automatic logic [CODE_W-1:0] next_code(input logic [CODE_W-1:0] cur,
                                                  input logic [CODE_W-1:0] stp,
                                                  input logic [CODE_W-1:0] lim);
    logic [SUM_W-1:0] sum;
    logic [CODE_W-1:0] inc;
    inc = (stp == '0) ? {{(CODE_W-1){1'b0}}, 1'b1} : stp;
    sum = {1'b0, cur} + {1'b0, inc};
    if (sum > {1'b0, lim}) return lim;
    return sum[CODE_W-1:0];
  endfunction

  assign busy     = (state == ST_SWEEP);
  assign lock_evt = busy & (dec == DEC_LOCK);
  assign fail_evt = busy & (dec == DEC_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      code      <= '0;
      prev_lag  <= 1'b0;
      have_prev <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cal_en) begin
            state     <= ST_SWEEP;
            code      <= code_min;
            prev_lag  <= 1'b0;
            have_prev <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
          end
        end
        ST_SWEEP: begin
          if (!cal_en) begin
            state <= ST_IDLE;
          end else begin
            unique case (dec)
              DEC_STEP: begin
                code      <= next_code(code, code_step, code_max);
                prev_lag  <= pd_lag;
                have_prev <= 1'b1;
              end
              DEC_LOCK: begin
                state <= ST_FINISH;
                done  <= 1'b1;
              end
              DEC_FAIL: begin
                state <= ST_FINISH;
                done  <= 1'b1;
                err   <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_FINISH: begin
          if (!cal_en) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clk_ref_align_cal.sv
module clk_ref_align_cal
  import cal_align_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_en,
  input  logic [CODE_W-1:0]   cfg_code_min,
  input  logic [CODE_W-1:0]   cfg_code_max,
  input  logic [CODE_W-1:0]   cfg_step,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                ref_in,
  input  logic                pd_lag,
  output logic [CODE_W-1:0]   dly_code,
  output logic                busy,
  output logic                done,
  output logic                err
);

  // internal events, visible to the bound checker
  logic     ref_rise;
  logic     sample_evt;
  logic     lock_evt;
  logic     fail_evt;
  logic     prev_lag;
  logic     have_prev;
  cal_dec_e dec;

  cal_ref_period_counter #(.SETTLE_W(SETTLE_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .ref_in     (ref_in),
    .settle_cfg (cfg_settle),
    .ref_rise   (ref_rise),
    .sample_evt (sample_evt)
  );

  cal_phase_decider #(.CODE_W(CODE_W)) u_decide (
    .sample_evt (sample_evt),
    .pd_lag     (pd_lag),
    .prev_lag   (prev_lag),
    .have_prev  (have_prev),
    .code       (dly_code),
    .code_max   (cfg_code_max),
    .dec        (dec)
  );

  cal_search_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_en    (cal_en),
    .code_min  (cfg_code_min),
    .code_max  (cfg_code_max),
    .code_step (cfg_step),
    .pd_lag    (pd_lag),
    .dec       (dec),
    .code      (dly_code),
    .prev_lag  (prev_lag),
    .have_prev (have_prev),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .lock_evt  (lock_evt),
    .fail_evt  (fail_evt)
  );

endmodule

// File: rtl/cal_align_checker.sv
module cal_align_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_en,
  input logic [CODE_W-1:0] cfg_code_min,
  input logic [CODE_W-1:0] dly_code,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sample_evt,
  input logic              lock_evt,
  input logic              fail_evt
);

  logic seen_edge;
  initial seen_edge = 1'b0;
  always @(posedge clk) seen_edge <= 1'b1;

  // R1: outputs cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n && seen_edge) begin
      p_reset_clear_r1: assert (dly_code == '0 && !busy && !done && !err);
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && cal_en) |=> (busy && dly_code == $past(cfg_code_min)));

  p_settle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cal_en && !sample_evt) |=> $stable(dly_code));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cal_en && sample_evt && !lock_evt && !fail_evt)
      |=> (busy && dly_code > $past(dly_code)));

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt && cal_en) |=> (done && !err && !busy && $stable(dly_code)));

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && cal_en) |=> (done && err && !busy && $stable(dly_code)));

  p_err_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_finish_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_en) |=> (done && $stable(err) && $stable(dly_code)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> (!busy && !done && !err && $stable(dly_code)));

endmodule

bind clk_ref_align_cal cal_align_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cal_en       (cal_en),
  .cfg_code_min (cfg_code_min),
  .dly_code     (dly_code),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .sample_evt   (sample_evt),
  .lock_evt     (lock_evt),
  .fail_evt     (fail_evt)
);

// File: tb/sim_clk_ref_align_cal.sv
`timescale 1ns/1ps
module sim_clk_ref_align_cal;

  localparam int CW = 6;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_en = 1'b0;
  logic [CW-1:0] cfg_code_min = '0;
  logic [CW-1:0] cfg_code_max = '0;
  logic [CW-1:0] cfg_step = '0;
  logic [SW-1:0] cfg_settle = '0;
  logic          ref_in = 1'b0;
  logic          pd_lag = 1'b0;
  logic [CW-1:0] dly_code;
  logic          busy, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // stimulus knobs
  int ref_half = 4;
  int ref_ph = 0;
  int pd_thresh = 0;
  bit pd_force_en = 0;
  bit pd_force = 0;

  // reference model state
  int m_state = 0;  // 0 idle, 1 sweeping, 2 finished
  int m_code = 0;
  int m_cnt = 0;
  bit m_done = 0, m_err = 0, m_prev = 0, m_have = 0, m_refq = 0;

  always #5 clk = ~clk;

  clk_ref_align_cal #(.CODE_W(CW), .SETTLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en),
    .cfg_code_min(cfg_code_min), .cfg_code_max(cfg_code_max),
    .cfg_step(cfg_step), .cfg_settle(cfg_settle),
    .ref_in(ref_in), .pd_lag(pd_lag),
    .dly_code(dly_code), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drivers of reference and phase detector, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      ref_ph = (ref_ph + 1) % (2 * ref_half);
      ref_in = (ref_ph < ref_half);
      pd_lag = pd_force_en ? pd_force : (int'(dly_code) >= pd_thresh);
    end
  end

  // behavioural model, updated on the same edge as the design
  always @(posedge clk) begin
    bit rise;
    int tgt, stp, nxt;
    if (!rst_n) begin
      m_state = 0; m_code = 0; m_cnt = 0; m_done = 0; m_err = 0;
      m_prev = 0; m_have = 0; m_refq = 0;
    end else begin
      rise = ref_in && !m_refq;
      m_refq = ref_in;
      tgt = (cfg_settle == 0) ? 1 : int'(cfg_settle);
      stp = (cfg_step == 0) ? 1 : int'(cfg_step);
      case (m_state)
        0: if (cal_en) begin
             m_state = 1; m_code = int'(cfg_code_min); m_cnt = 0;
             m_have = 0; m_prev = 0; m_done = 0; m_err = 0;
           end
        1: if (!cal_en) m_state = 0;
           else if (rise) begin
             m_cnt++;
             if (m_cnt >= tgt) begin
               m_cnt = 0;
               if (m_have && !m_prev && pd_lag) begin
                 m_state = 2; m_done = 1;
               end else if (m_code >= int'(cfg_code_max)) begin
                 m_state = 2; m_done = 1; m_err = 1;
               end else begin
                 nxt = m_code + stp;
                 m_code = (nxt > int'(cfg_code_max)) ? int'(cfg_code_max) : nxt;
                 m_prev = pd_lag; m_have = 1;
               end
             end
           end
        default: if (!cal_en) begin m_state = 0; m_done = 0; m_err = 0; end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    string tag;
    if (rst_n && !finished) begin
      tag = (m_state == 1) ? "R3_R4" : (m_err ? "R6" : (m_done ? "R7" : "R8"));
      chk(int'(dly_code) == m_code, tag, int'(dly_code), m_code);
      chk(busy == (m_state == 1) && done == m_done && err == m_err, tag,
          {busy, done, err}, {(m_state == 1), m_done, m_err});
    end
  end

  // expected outcome from the sweep parameters and detector threshold
  task automatic expect_outcome(input int mn, input int mx, input int st, input int th,
                                output int code, output bit e);
    int c = mn;
    int s = (st == 0) ? 1 : st;
    bit have = 0, prev = 0, lag, fin = 0;
    while (!fin) begin
      lag = (c >= th);
      if (have && !prev && lag) begin code = c; e = 0; fin = 1; end
      else if (c >= mx) begin code = c; e = 1; fin = 1; end
      else begin
        prev = lag; have = 1;
        c = (c + s > mx) ? mx : c + s;
      end
    end
  endtask

  task automatic run_case(input int mn, input int mx, input int st, input int se,
                          input int th, input int half);
    int ecode, held;
    bit eerr;
    int wait_cyc = 0;
    @(negedge clk);
    cfg_code_min = CW'(mn); cfg_code_max = CW'(mx);
    cfg_step = CW'(st); cfg_settle = SW'(se);
    ref_half = half; pd_thresh = th; pd_force_en = 0;
    cal_en = 1;
    @(negedge clk);
    chk(busy && int'(dly_code) == mn, "R2", int'(dly_code), mn);
    while (!done && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
    end
    expect_outcome(mn, mx, st, th, ecode, eerr);
    chk(done && !busy, eerr ? "R6" : "R5", {done, busy}, 2);
    chk(int'(dly_code) == ecode, eerr ? "R6" : "R5", int'(dly_code), ecode);
    chk(err == eerr, eerr ? "R6" : "R5", err, eerr);
    // R7: detector and reference activity after finish change nothing
    held = int'(dly_code);
    pd_force_en = 1;
    for (int i = 0; i < 12; i++) begin
      pd_force = i[0];
      @(negedge clk);
    end
    chk(done && err == eerr && int'(dly_code) == held, "R7", int'(dly_code), held);
    pd_force_en = 0;
    cal_en = 0;
    @(negedge clk);
    chk(!busy && !done && !err, "R8", {busy, done, err}, 0);
    chk(int'(dly_code) == held, "R8", int'(dly_code), held);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk(dly_code == 0 && !busy && !done && !err, "R1", {dly_code, busy, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R1", {busy, done}, 0);

    // R5: lock after several steps, two periods of settling
    run_case(4, 40, 3, 2, 20, 4);
    // R4: step 0 and settle 0 both count as 1
    run_case(10, 14, 0, 0, 13, 3);
    // R6: no change before the clipped top code
    run_case(2, 30, 5, 1, 63, 5);
    // R5 corner: lag on first sample does not lock, run ends in error
    run_case(0, 8, 4, 3, 0, 2);
    // R4: clipping lands exactly on the transition
    run_case(1, 9, 6, 1, 9, 4);

    // R8: abort mid-sweep, then restart from the bottom (R2)
    @(negedge clk);
    cfg_code_min = 3; cfg_code_max = 50; cfg_step = 2; cfg_settle = 2;
    ref_half = 3; pd_thresh = 60;
    cal_en = 1;
    repeat (40) @(negedge clk);
    held = int'(dly_code);
    chk(busy && held > 3, "R3", held, 4);
    cal_en = 0;
    @(negedge clk);
    chk(!busy && !done && int'(dly_code) == held, "R8", int'(dly_code), held);
    repeat (6) @(negedge clk);
    chk(!busy && int'(dly_code) == held, "R8", int'(dly_code), held);
    cal_en = 1;
    @(negedge clk);
    chk(busy && dly_code == 3, "R2", int'(dly_code), 3);
    cal_en = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule